// File: doc/BRIEF.md
# Flash Software-Protection Command Decoder

This block sits on the device side of a parallel flash and watches the stream of host bus writes. It follows a fixed unlock prefix of several writes before any alteration of the array can begin. It recognises five commands: byte program, sector erase, chip erase, identification entry and identification exit. When a program or erase command completes, it emits a one-cycle start pulse together with a latched target address and data byte. The array controller uses these to run the actual operation.

The decoder also steers the read path. The array controller raises a busy input while an internal program or erase runs. During that time reads return status, and every host write is dropped. In identification mode, reads return the maker and density codes. Otherwise reads go to the array.

A write that does not fit the expected next step returns the sequence to its idle point. That write is consumed and does not begin a new sequence.

Top module: `flash_cmd_dec`

## Requirements
- R1: A byte program is recognised when the first three accepted writes are AAh to 5555h, 55h to 2AAAh and A0h to 5555h, and a fourth accepted write follows at any address. In the cycle after that fourth write, `prog_start` is high for exactly one cycle, `op_addr` equals the fourth write's address and `op_data` equals its data.
- R2: A sector erase is recognised when six accepted writes arrive in this order: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address. In the cycle after the sixth write, `sect_erase_start` pulses for one cycle. `op_addr` is then the sixth write's address with bits 11:0 cleared (4 KiB sectors), and `op_data` is FFh.
- R3: A chip erase uses the same first five writes as R2, and its sixth write is 10h at 5555h. In the cycle after the sixth write, `chip_erase_start` pulses for one cycle, with `op_addr` = 0 and `op_data` = FFh.
- R4: Every command address is compared on bits 14:0 only, so 5555h and 2AAAh match at every alias in the address space.
- R5: Any accepted write that is not the expected next step returns the sequence to idle. The offending write does not begin a new sequence, and no start pulse results.
- R6: Identification entry uses the prefix writes AAh@5555h and 55h@2AAAh, followed by 90h@5555h. From the next cycle `rd_sel` is 1 (identification). `id_byte` reads BFh at `rd_addr` 0, reads D5h/D6h/D7h at `rd_addr` 1 when ADDR_W is 17/18/19, and reads 00h at any other address.
- R7: Identification exit uses the same two prefix writes followed by F0h@5555h, and from the next cycle `rd_sel` is 0 (array). Identification mode survives aborted sequences and ends only through this exit.
- R8: While `busy` is high, `rd_sel` is 2 (status) and every write is ignored. An ignored write causes no start pulse, does not alter identification mode (the exit command included) and does not move the sequence position.
- R9: After reset, `rd_sel` is 0, all start pulses are low and `op_addr` and `op_data` are 0.
- R10: On the sixth erase write, data other than 30h, or data 10h at an address other than 5555h, aborts with no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data |
| busy | input | 1 | Internal program/erase in progress |
| rd_addr | input | ADDR_W | Host read address, used for identification codes |
| prog_start | output | 1 | One-cycle byte program start |
| sect_erase_start | output | 1 | One-cycle sector erase start |
| chip_erase_start | output | 1 | One-cycle chip erase start |
| op_addr | output | ADDR_W | Latched operation address |
| op_data | output | 8 | Latched operation data |
| rd_sel | output | 2 | Read source: 0 array, 1 identification, 2 status |
| id_byte | output | 8 | Identification code for rd_addr |

## Verification
Several properties are checked on every cycle:
- The three start pulses are never high together.
- No start pulse follows a cycle in which busy was high.
- A program start always carries the data of the write before it.
- A sector start address is sector aligned.
- A chip start follows a 10h write at a 5555h alias.
- In identification mode the maker code appears at address 0.

Only the bench's scenarios can show whether whole sequences are accepted or rejected: aborts that consume the breaking write, aliased unlock addresses, bad sixth-cycle codes, persistence of identification mode, and a sequence position held across writes dropped while busy.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
    localparam int KEY_W = 15;

    localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] CODE_UNL_A   = 8'hAA;
    localparam logic [7:0] CODE_UNL_B   = 8'h55;
    localparam logic [7:0] CODE_PROG    = 8'hA0;
    localparam logic [7:0] CODE_ERASE   = 8'h80;
    localparam logic [7:0] CODE_ID_IN   = 8'h90;
    localparam logic [7:0] CODE_ID_OUT  = 8'hF0;
    localparam logic [7:0] CODE_SECTOR  = 8'h30;
    localparam logic [7:0] CODE_CHIP    = 8'h10;

    localparam logic [7:0] MAKER_CODE   = 8'hBF;
    localparam logic [7:0] ERASED_BYTE  = 8'hFF;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PGM,
        SQ_ERA3,
        SQ_ERA4,
        SQ_ERA5
    } seq_e;

    typedef enum logic [1:0] {
        RSEL_ARRAY  = 2'd0,
        RSEL_IDENT  = 2'd1,
        RSEL_STATUS = 2'd2
    } rsel_e;
endpackage

// File: rtl/key_addr_match.sv
`timescale 1ns/1ps
module key_addr_match
    import flash_cmd_pkg::*;
(
    input  logic [KEY_W-1:0] key_addr,
    output logic             hit_a,
    output logic             hit_b
);
    always_comb begin
        hit_a = (key_addr == KEY_ADDR_A);
        hit_b = (key_addr == KEY_ADDR_B);
    end
endmodule

// File: rtl/id_rom.sv
`timescale 1ns/1ps
module id_rom
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        id_byte
);
    logic [7:0] dev_code;

    generate
        if (ADDR_W <= 17) begin : g_d17
            assign dev_code = 8'hD5;
        end else if (ADDR_W == 18) begin : g_d18
            assign dev_code = 8'hD6;
        end else begin : g_d19
            assign dev_code = 8'hD7;
        end
    endgenerate

    always_comb begin
        if (rd_addr == '0)
            id_byte = MAKER_CODE;
        else if (rd_addr == ADDR_W'(1))
            id_byte = dev_code;
        else
            id_byte = 8'h00;
    end
endmodule

// File: rtl/cmd_seq_fsm.sv
`timescale 1ns/1ps
module cmd_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int SECT_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              hit_a,
    input  logic              hit_b,
    output logic              prog_start,
    output logic              sect_start,
    output logic              chip_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              id_mode
);
    localparam logic [ADDR_W-1:0] SECT_MASK =
        {{(ADDR_W-SECT_LSB){1'b1}}, {SECT_LSB{1'b0}}};

    typedef struct packed {
        seq_e              seq;
        logic              id;
        logic              prog;
        logic              sect;
        logic              chip;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } fsm_t;

    fsm_t st_q, st_d;
    logic accept;

    always_comb begin
        accept    = wr_en && !busy;
        st_d      = st_q;
        st_d.prog = 1'b0;
        st_d.sect = 1'b0;
        st_d.chip = 1'b0;
        if (accept) begin
            st_d.seq = SQ_IDLE;
            unique case (st_q.seq)
                SQ_IDLE: if (hit_a && wr_data == CODE_UNL_A) st_d.seq = SQ_UNL1;
                SQ_UNL1: if (hit_b && wr_data == CODE_UNL_B) st_d.seq = SQ_UNL2;
                SQ_UNL2: begin
                    if (hit_a) begin
                        if (wr_data == CODE_PROG)   st_d.seq = SQ_PGM;
                        if (wr_data == CODE_ERASE)  st_d.seq = SQ_ERA3;
                        if (wr_data == CODE_ID_IN)  st_d.id  = 1'b1;
                        if (wr_data == CODE_ID_OUT) st_d.id  = 1'b0;
                    end
                end
                SQ_PGM: begin
                    st_d.prog = 1'b1;
                    st_d.addr = wr_addr;
                    st_d.data = wr_data;
                end
                SQ_ERA3: if (hit_a && wr_data == CODE_UNL_A) st_d.seq = SQ_ERA4;
                SQ_ERA4: if (hit_b && wr_data == CODE_UNL_B) st_d.seq = SQ_ERA5;
                SQ_ERA5: begin
                    if (wr_data == CODE_SECTOR) begin
                        st_d.sect = 1'b1;
                        st_d.addr = wr_addr & SECT_MASK;
                        st_d.data = ERASED_BYTE;
                    end else if (hit_a && wr_data == CODE_CHIP) begin
                        st_d.chip = 1'b1;
                        st_d.addr = '0;
                        st_d.data = ERASED_BYTE;
                    end
                end
                default: st_d.seq = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{seq: SQ_IDLE, id: 1'b0, prog: 1'b0, sect: 1'b0,
                      chip: 1'b0, addr: '0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign prog_start = st_q.prog;
    assign sect_start = st_q.sect;
    assign chip_start = st_q.chip;
    assign op_addr    = st_q.addr;
    assign op_data    = st_q.data;
    assign id_mode    = st_q.id;
endmodule

// File: rtl/flash_cmd_dec.sv
`timescale 1ns/1ps
module flash_cmd_dec
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int SECT_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prog_start,
    output logic              sect_erase_start,
    output logic              chip_erase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic [1:0]        rd_sel,
    output logic [7:0]        id_byte
);
    logic hit_a, hit_b, id_mode;

    key_addr_match i_match (
        .key_addr (wr_addr[KEY_W-1:0]),
        .hit_a    (hit_a),
        .hit_b    (hit_b)
    );

    cmd_seq_fsm #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .busy       (busy),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .hit_a      (hit_a),
        .hit_b      (hit_b),
        .prog_start (prog_start),
        .sect_start (sect_erase_start),
        .chip_start (chip_erase_start),
        .op_addr    (op_addr),
        .op_data    (op_data),
        .id_mode    (id_mode)
    );

    id_rom #(.ADDR_W(ADDR_W)) i_idrom (
        .rd_addr (rd_addr),
        .id_byte (id_byte)
    );

    always_comb begin
        if (busy)
            rd_sel = RSEL_STATUS;
        else if (id_mode)
            rd_sel = RSEL_IDENT;
        else
            rd_sel = RSEL_ARRAY;
    end
endmodule

// File: rtl/flash_cmd_dec_chk.sv
`timescale 1ns/1ps
module flash_cmd_dec_chk #(
    parameter int ADDR_W   = 18,
    parameter int SECT_LSB = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              busy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              prog_start,
    input logic              sect_erase_start,
    input logic              chip_erase_start,
    input logic [ADDR_W-1:0] op_addr,
    input logic [7:0]        op_data,
    input logic [1:0]        rd_sel,
    input logic [7:0]        id_byte
);
    logic any_start;
    assign any_start = prog_start | sect_erase_start | chip_erase_start;

    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_start, sect_erase_start, chip_erase_start})); // R1

    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !any_start); // R8

    AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        any_start |-> $past(wr_en)); // R5

    AST_PROG_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> (op_data == $past(wr_data) && op_addr == $past(wr_addr))); // R1

    AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start); // R1

    AST_SECT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        sect_erase_start |-> (op_addr[SECT_LSB-1:0] == '0 && op_data == 8'hFF)); // R2

    AST_CHIP_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase_start |-> ($past(wr_addr[14:0]) == 15'h5555 && $past(wr_data) == 8'h10)); // R3

    AST_ID_MAKER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd1 && rd_addr == '0) |-> id_byte == 8'hBF); // R6

    AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rd_sel == 2'd2); // R8
endmodule

bind flash_cmd_dec flash_cmd_dec_chk #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) i_chk (.*);

// File: tb/test_flash_cmd_dec.sv
`timescale 1ns/1ps
module test_flash_cmd_dec;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          prog_start, sect_erase_start, chip_erase_start;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data;
    logic [1:0]    rd_sel;
    logic [7:0]    id_byte;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 1'b0;

    int            exp_kind[$];
    logic [AW-1:0] exp_addr[$];
    logic [7:0]    exp_data[$];
    string         exp_tag[$];

    always #2.5 clk = ~clk;

    flash_cmd_dec #(.ADDR_W(AW)) i_flash_cmd_dec (.*);

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected start events as the design produces them
    always @(negedge clk) begin
        if (rst_n && !done && (prog_start || sect_erase_start || chip_erase_start)) begin
            int kind;
            kind = prog_start ? 0 : (sect_erase_start ? 1 : 2);
            n_total++;
            if (exp_kind.size() == 0) begin
                n_bad++;
                $display("FAIL R5 unexpected start: actual kind=%0d addr=%0h expected none",
                         kind, op_addr);
            end else begin
                int            ek;
                logic [AW-1:0] ea;
                logic [7:0]    ed;
                string         et;
                ek = exp_kind.pop_front();
                ea = exp_addr.pop_front();
                ed = exp_data.pop_front();
                et = exp_tag.pop_front();
                if (kind != ek || op_addr !== ea || op_data !== ed ||
                    $countones({prog_start, sect_erase_start, chip_erase_start}) != 1) begin
                    n_bad++;
                    $display("FAIL %s: actual kind=%0d addr=%0h data=%0h expected kind=%0d addr=%0h data=%0h",
                             et, kind, op_addr, op_data, ek, ea, ed);
                end
            end
        end
    end

    task automatic push(input int k, input logic [AW-1:0] a, input logic [7:0] d, input string t);
        exp_kind.push_back(k);
        exp_addr.push_back(a);
        exp_data.push_back(d);
        exp_tag.push_back(t);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic prefix(input logic [7:0] code);
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
        wr(18'h05555, code);
    endtask

    task automatic erase6(input logic [AW-1:0] a, input logic [7:0] d);
        prefix(8'h80);
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
        wr(a, d);
    endtask

    task automatic drain(input string tag);
        repeat (3) @(negedge clk);
        chk(32'(exp_kind.size()), 32'd0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(32'(rd_sel), 32'd0, "R9 rd_sel");
        chk(32'({prog_start, sect_erase_start, chip_erase_start}), 32'd0, "R9 pulses");
        chk(32'(op_addr), 32'd0, "R9 op_addr");
        chk(32'(op_data), 32'd0, "R9 op_data");

        // R1 plain program
        prefix(8'hA0);
        push(0, 18'h01234, 8'h5A, "R1 program");
        wr(18'h01234, 8'h5A);
        drain("R1 drained");

        // R4 aliased key addresses
        wr(18'h1D555, 8'hAA);
        wr(18'h0AAAA, 8'h55);
        wr(18'h3D555, 8'hA0);
        push(0, 18'h3FFFF, 8'h00, "R4 aliased program");
        wr(18'h3FFFF, 8'h00);
        drain("R4 drained");

        // R2 sector erase
        push(1, 18'h2A000, 8'hFF, "R2 sector erase");
        erase6(18'h2A7C3, 8'h30);
        drain("R2 drained");

        // R3 chip erase (aliased 5555 on last cycle)
        push(2, 18'h00000, 8'hFF, "R3 chip erase");
        erase6(18'h25555, 8'h10);
        drain("R3 drained");

        // R5 abort consumes the breaking write
        wr(18'h05555, 8'hAA);
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
        wr(18'h05555, 8'hA0);
        wr(18'h00100, 8'h11);
        wr(18'h05556, 8'hAA);
        wr(18'h02AAA, 8'h55);
        wr(18'h05555, 8'hA0);
        wr(18'h00200, 8'h22);
        drain("R5 no start after abort");
        prefix(8'hA0);
        push(0, 18'h00300, 8'h33, "R5 recovery program");
        wr(18'h00300, 8'h33);
        drain("R5 recovery drained");

        // R10 bad sixth cycle
        erase6(18'h05555, 8'h20);
        erase6(18'h01234, 8'h10);
        drain("R10 no erase start");
        chk(32'(rd_sel), 32'd0, "R10 rd_sel array");

        // R6 identification entry
        prefix(8'h90);
        chk(32'(rd_sel), 32'd1, "R6 rd_sel ident");
        rd_addr = 18'h0; #1;
        chk(32'(id_byte), 32'hBF, "R6 maker");
        rd_addr = 18'h1; #1;
        chk(32'(id_byte), 32'hD6, "R6 device");
        rd_addr = 18'h2; #1;
        chk(32'(id_byte), 32'h00, "R6 other");

        // R7 persists over abort, ends on exit
        wr(18'h05555, 8'h77);
        wr(18'h05555, 8'hAA);
        wr(18'h01111, 8'h55);
        chk(32'(rd_sel), 32'd1, "R7 ident persists");
        prefix(8'hF0);
        chk(32'(rd_sel), 32'd0, "R7 exit to array");

        // R8 busy: status select, exit ignored, position held
        prefix(8'h90);
        @(negedge clk); busy = 1'b1; #1;
        chk(32'(rd_sel), 32'd2, "R8 status select");
        prefix(8'hF0);
        prefix(8'hA0);
        wr(18'h00400, 8'h44);
        @(negedge clk); busy = 1'b0; #1;
        chk(32'(rd_sel), 32'd1, "R8 exit ignored while busy");
        drain("R8 no start while busy");
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
        @(negedge clk); busy = 1'b1;
        wr(18'h00000, 8'h00);
        @(negedge clk); busy = 1'b0;
        wr(18'h05555, 8'hA0);
        push(0, 18'h00500, 8'h55, "R8 position held");
        wr(18'h00500, 8'h55);
        drain("R8 held drained");
        prefix(8'hF0);
        chk(32'(rd_sel), 32'd0, "R7 final exit");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule